// File: doc/BRIEF.md
# Floating-Point Chop/Round and Pack Stage

This stage sits at the end of an add, subtract, multiply or divide datapath. It receives an unrounded result: a sign, a signed biased exponent wider than the stored field, and a normalised fraction. That fraction has its hidden leading one at the top and two guard bits below its least significant bit. The stage reduces the fraction to 24 significant bits (single) or 56 significant bits (double). It either drops the extra bits or rounds half-up on the first dropped bit. If rounding carries out of the fraction, it renormalises. It then checks the exponent against the 8-bit stored range and packs sign, exponent and hidden-bit-free fraction, together with overflow, underflow and zero flags.

An out-of-range exponent is never saturated. On overflow the stored exponent is the low eight bits of the true exponent, so it reads 256 too small, and the fraction is kept. On underflow with the underflow interrupt enabled, the low eight bits are kept as well, so a non-zero stored value reads 256 too large. With that interrupt disabled, the result is replaced by an exact zero. This lets interrupt software rebuild the correct answer.

Both sides are valid/ready streams with one output register. An input beat is taken when `in_valid && in_ready`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a full-rate stream passes one result per cycle. While `out_valid` is high and `out_ready` is low, the output holds, and no new input is taken.

Top module: `fpk_pack_stage`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted beat appears on the outputs with `out_valid` high in the next cycle. While `out_valid && !out_ready`, every output holds its value. `out_valid` is 0 after reset.
- R2: With `in_rnd`=0 (chop), the stored fraction is the significant bits of `in_frac` with no increment, whatever the guard bits hold.
- R3: With `in_rnd`=1, the rounding bit is the first bit below the kept fraction (bit 1 of `in_frac` in double mode). If that bit is 1, one LSB is added. If it is 0, the result equals the chopped result, even if lower bits are set.
- R4: If rounding carries out of an all-ones fraction, the fraction becomes the hidden one with a zero field, and the exponent is incremented before the range check.
- R5: `in_dbl`=0 selects single precision. The kept bits are `in_frac[57:34]`, the rounding bit is bit 33, the field is in `out_frac[54:32]`, and `out_frac[31:0]` is 0. `in_dbl`=1 keeps `in_frac[57:2]` into `out_frac[54:0]`.
- R6: An input biased exponent of 0 gives an exact zero: all output bits 0, sign 0, `out_zero`=1, and `out_ovf`=`out_unf`=0.
- R7: A rounded exponent above 255 sets `out_ovf`. It stores the low eight bits of that exponent and keeps the sign and fraction.
- R8: A rounded exponent of 0 or below, with `in_unf_ie`=1, sets `out_unf`. It stores the low eight bits (exponent + 256 when negative) and keeps the sign and fraction.
- R9: A rounded exponent of 0 or below, with `in_unf_ie`=0, sets `out_unf` and `out_zero` and outputs an all-zero, positive value.
- R10: A rounded exponent in 1..255 is stored unchanged, with all three flags 0. `in_exp` is two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can take a beat |
| in_sign | input | 1 | Result sign |
| in_exp | input | 12 | Signed biased exponent |
| in_frac | input | 58 | Normalised fraction, hidden one at bit 57, two guard bits at [1:0] |
| in_dbl | input | 1 | 1 = 56-bit fraction, 0 = 24-bit |
| in_rnd | input | 1 | 1 = round, 0 = chop |
| in_unf_ie | input | 1 | Underflow interrupt enable |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_sign | output | 1 | Stored sign |
| out_exp | output | 8 | Stored biased exponent |
| out_frac | output | 55 | Stored fraction without hidden bit |
| out_ovf | output | 1 | Exponent overflow |
| out_unf | output | 1 | Exponent underflow |
| out_zero | output | 1 | Result is exact zero |

## Verification
The bench targets the rounding boundaries. It rounds on a set rounding bit with a clear rounding bit but a set lower guard bit, which would expose a design that uses the wrong bit or a sticky OR. It drives an all-ones fraction that carries, where a missing renormalisation would give a zero fraction with an unchanged exponent. It also checks the single-precision bit positions, where an off-by-one would leave tail bits set or round at bit 34. Exponent edges 255+carry, -1+carry, -5 and 300 under both underflow enables catch saturation instead of wrap, an underflow that ignores its enable, and flags lost on a zero result. Random back-pressure catches a stage that drops or overwrites a held beat.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  parameter int FRAC_D    = 56;  // double significant bits incl. hidden one
  parameter int FRAC_S    = 24;  // single significant bits incl. hidden one
  parameter int GUARD     = 2;   // guard bits below LSB
  parameter int EXP_IN_W  = 12;  // signed biased exponent in
  parameter int EXP_OUT_W = 8;   // stored biased exponent

  localparam int IN_W       = FRAC_D + GUARD;
  localparam int OUT_FRAC_W = FRAC_D - 1;
  localparam int TAIL_W     = FRAC_D - FRAC_S;
  localparam int EXP_WIDE_W = EXP_IN_W + 1;

  typedef struct packed {
    logic                  sign;
    logic [EXP_OUT_W-1:0]  exp;
    logic [OUT_FRAC_W-1:0] frac;
    logic                  ovf;
    logic                  unf;
    logic                  zero;
  } fpk_res_t;
endpackage

// File: rtl/fpk_round.sv
module fpk_round
  import fpk_pkg::*;
(
  input  logic [IN_W-1:0]   frac_i,
  input  logic              dbl_i,
  input  logic              rnd_i,
  output logic [FRAC_D-1:0] mant_o,
  output logic              carry_o
);
  logic [FRAC_D-1:0] kept;
  logic [FRAC_D-1:0] step;
  logic [FRAC_D:0]   sum;
  logic              rbit;
  logic              unused_guard;

  assign unused_guard = frac_i[0];

  always_comb begin
    kept = frac_i[IN_W-1:GUARD];
    if (!dbl_i) kept[TAIL_W-1:0] = '0;
    rbit = dbl_i ? frac_i[GUARD-1] : frac_i[GUARD+TAIL_W-1];
    step = dbl_i ? FRAC_D'(1) : (FRAC_D'(1) << TAIL_W);
    sum  = {1'b0, kept} + ((rnd_i && rbit) ? {1'b0, step} : '0);
    carry_o = sum[FRAC_D];
    mant_o  = carry_o ? sum[FRAC_D:1] : sum[FRAC_D-1:0];
  end
endmodule

// File: rtl/fpk_range.sv
module fpk_range
  import fpk_pkg::*;
(
  input  logic                sign_i,
  input  logic [EXP_IN_W-1:0] exp_i,
  input  logic [FRAC_D-1:0]   mant_i,
  input  logic                carry_i,
  input  logic                unf_ie_i,
  output fpk_res_t            res_o
);
  localparam int MAX_EXP = (1 << EXP_OUT_W) - 1;

  logic signed [EXP_WIDE_W-1:0] e_adj;
  logic over, under, in_zero;
  logic unused_hidden;

  assign unused_hidden = mant_i[FRAC_D-1];

  always_comb begin
    e_adj   = $signed({exp_i[EXP_IN_W-1], exp_i}) + $signed({{(EXP_WIDE_W-1){1'b0}}, carry_i});
    over    = e_adj > $signed(EXP_WIDE_W'(MAX_EXP));
    under   = e_adj <= $signed(EXP_WIDE_W'(0));
    in_zero = (exp_i == '0);
    res_o   = '0;
    if (in_zero) begin
      res_o.zero = 1'b1;
    end else if (under && !unf_ie_i) begin
      res_o.unf  = 1'b1;
      res_o.zero = 1'b1;
    end else begin
      res_o.sign = sign_i;
      res_o.exp  = e_adj[EXP_OUT_W-1:0];
      res_o.frac = mant_i[FRAC_D-2:0];
      res_o.ovf  = over;
      res_o.unf  = under;
    end
  end
endmodule

// File: rtl/fpk_stage.sv
module fpk_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign s_ready = !v_q || m_ready;
  assign m_valid = v_q;
  assign m_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (s_valid && s_ready) begin
      v_q <= 1'b1;
      d_q <= s_data;
    end else if (m_ready) begin
      v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fpk_pack_stage.sv
module fpk_pack_stage
  import fpk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_sign,
  input  logic [EXP_IN_W-1:0]   in_exp,
  input  logic [IN_W-1:0]       in_frac,
  input  logic                  in_dbl,
  input  logic                  in_rnd,
  input  logic                  in_unf_ie,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_sign,
  output logic [EXP_OUT_W-1:0]  out_exp,
  output logic [OUT_FRAC_W-1:0] out_frac,
  output logic                  out_ovf,
  output logic                  out_unf,
  output logic                  out_zero
);
  logic [FRAC_D-1:0] mant;
  logic              carry;
  fpk_res_t          res_d, res_q;

  fpk_round u_round (
    .frac_i (in_frac),
    .dbl_i  (in_dbl),
    .rnd_i  (in_rnd),
    .mant_o (mant),
    .carry_o(carry)
  );

  fpk_range u_range (
    .sign_i  (in_sign),
    .exp_i   (in_exp),
    .mant_i  (mant),
    .carry_i (carry),
    .unf_ie_i(in_unf_ie),
    .res_o   (res_d)
  );

  fpk_stage #(.W($bits(fpk_res_t))) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (res_d),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (res_q)
  );

  assign out_sign = res_q.sign;
  assign out_exp  = res_q.exp;
  assign out_frac = res_q.frac;
  assign out_ovf  = res_q.ovf;
  assign out_unf  = res_q.unf;
  assign out_zero = res_q.zero;
endmodule

// File: rtl/fpk_pack_chk.sv
module fpk_pack_chk
  import fpk_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_IN_W-1:0]   in_exp,
  input logic                  in_dbl,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_sign,
  input logic [EXP_OUT_W-1:0]  out_exp,
  input logic [OUT_FRAC_W-1:0] out_frac,
  input logic                  out_ovf,
  input logic                  out_unf,
  input logic                  out_zero
);
  p_hold_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_sign, out_exp, out_frac, out_ovf, out_unf, out_zero}));

  p_ready_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_single_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_dbl |=> out_frac[TAIL_W-1:0] == '0);

  p_exp0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_exp == '0 |=> out_zero && !out_ovf && !out_unf);

  p_zero_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> !out_sign && out_exp == '0 && out_frac == '0);

  p_ovf_not_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> !out_zero && !out_unf);
endmodule

bind fpk_pack_stage fpk_pack_chk u_chk (.*);

// File: tb/fpk_pack_stage_tb.sv
module fpk_pack_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0, in_dbl = 1'b1, in_rnd = 1'b0, in_unf_ie = 1'b0;
  logic [11:0] in_exp = '0;
  logic [57:0] in_frac = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_sign, out_ovf, out_unf, out_zero;
  logic [7:0]  out_exp;
  logic [54:0] out_frac;

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "";

  always #2.5 clk = ~clk;

  fpk_pack_stage u_dut (.*);

  function automatic logic [66:0] ref_pack(logic s, logic [11:0] ex, logic [57:0] fr,
                                           logic dbl, logic rnd, logic uie);
    int n, sh, e;
    longint unsigned m, f;
    logic [54:0] ff;
    logic [7:0] eo;
    if (ex == 0) return {1'b0, 8'd0, 55'd0, 3'b001};
    n = dbl ? 56 : 24;
    sh = 58 - n;
    f = 64'(fr);
    m = f >> sh;
    if (rnd && ((f >> (sh - 1)) & 64'd1) == 64'd1) m = m + 1;
    e = int'($signed(ex));
    if ((m >> n) != 0) begin m = m >> 1; e = e + 1; end
    ff = 55'((m & ((64'd1 << (n - 1)) - 1)) << (56 - n));
    eo = 8'(e & 255);
    if (e > 255) return {s, eo, ff, 3'b100};
    if (e <= 0) begin
      if (!uie) return {1'b0, 8'd0, 55'd0, 3'b011};
      return {s, eo, ff, 3'b010};
    end
    return {s, eo, ff, 3'b000};
  endfunction

  function automatic string classify(logic [66:0] r);
    if (r[2]) return "R7";
    if (r[1] && r[0]) return "R9";
    if (r[1]) return "R8";
    if (r[0]) return "R6";
    return "R10";
  endfunction

  // reference model: one-entry output slot, updated at each rising edge
  logic        mv = 1'b0;
  logic [66:0] md = '0;
  string       mtag = "";
  logic [66:0] tmp_res;
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) mv = 1'b0;
    else if (in_valid && (!mv || out_ready)) begin
      tmp_res = ref_pack(in_sign, in_exp, in_frac, in_dbl, in_rnd, in_unf_ie);
      md = tmp_res;
      mtag = (cur_tag == "") ? classify(tmp_res) : cur_tag;
      mv = 1'b1;
    end else if (out_ready) mv = 1'b0;
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== (!mv || out_ready) || out_valid !== mv) begin
        fails++;
        $display("FAIL R1 handshake: got valid=%b ready=%b exp valid=%b ready=%b",
                 out_valid, in_ready, mv, !mv || out_ready);
      end
      if (mv) begin
        checks++;
        if ({out_sign, out_exp, out_frac, out_ovf, out_unf, out_zero} !== md) begin
          fails++;
          $display("FAIL %s data: got %h exp %h", mtag,
                   {out_sign, out_exp, out_frac, out_ovf, out_unf, out_zero}, md);
        end
      end
    end
  end

  task automatic send(string tag, logic s, logic [11:0] ex, logic [57:0] fr,
                      logic dbl, logic rnd, logic uie);
    @(posedge clk); #1;
    cur_tag = tag; in_valid = 1'b1; in_sign = s; in_exp = ex; in_frac = fr;
    in_dbl = dbl; in_rnd = rnd; in_unf_ie = uie;
    @(posedge clk); #1;
    in_valid = 1'b0; cur_tag = "";
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1 reset: got out_valid=%b exp 0", out_valid);
    end
    // R2 chop, R3 round, R4 carry (double)
    send("R2", 1'b0, 12'd100, 58'h3FF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0);
    send("R3", 1'b1, 12'd100, 58'h200_0000_0000_0002, 1'b1, 1'b1, 1'b0);
    send("R3", 1'b0, 12'd100, 58'h200_0000_0000_0001, 1'b1, 1'b1, 1'b0);
    send("R2", 1'b0, 12'd100, 58'h200_0000_0000_0003, 1'b1, 1'b0, 1'b0);
    send("R4", 1'b0, 12'd100, 58'h3FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
    // R5 single
    send("R5", 1'b0, 12'd60,  58'h200_0002_0000_0000, 1'b0, 1'b1, 1'b0);
    send("R5", 1'b1, 12'd60,  58'h3FF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0);
    send("R5", 1'b0, 12'd60,  58'h3FF_FFFE_0000_0000, 1'b0, 1'b1, 1'b0);
    send("R5", 1'b0, 12'd60,  58'h200_0001_FFFF_FFFF, 1'b0, 1'b1, 1'b0);
    // R6 zero input
    send("R6", 1'b1, 12'd0,   58'h3FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1);
    // R7 overflow, both enables, and via carry
    send("R7", 1'b1, 12'd300, 58'h2AA_AAAA_AAAA_AAAA, 1'b1, 1'b0, 1'b0);
    send("R7", 1'b0, 12'd300, 58'h2AA_AAAA_AAAA_AAAA, 1'b1, 1'b0, 1'b1);
    send("R7", 1'b0, 12'd255, 58'h3FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
    // R8 underflow enabled
    send("R8", 1'b1, 12'hFFB, 58'h255_5555_5555_5555, 1'b1, 1'b0, 1'b1);
    send("R8", 1'b0, 12'hFFF, 58'h3FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1);
    // R9 underflow disabled
    send("R9", 1'b1, 12'hFFB, 58'h255_5555_5555_5555, 1'b1, 1'b0, 1'b0);
    send("R9", 1'b0, 12'hFFF, 58'h3FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
    // R10 in range edges
    send("R10", 1'b1, 12'd255, 58'h300_0000_0000_0000, 1'b1, 1'b1, 1'b0);
    send("R10", 1'b0, 12'd1,   58'h200_0000_0000_0000, 1'b0, 1'b0, 1'b0);
    // R1 stall: hold output, second beat waits
    @(posedge clk); #1;
    out_ready = 1'b0; cur_tag = "R1";
    in_valid = 1'b1; in_exp = 12'd10; in_frac = 58'h211_1111_1111_1111; in_dbl = 1'b1;
    @(posedge clk); #1;
    in_exp = 12'd20; in_frac = 58'h322_2222_2222_2222;
    repeat (4) @(posedge clk);
    #1 out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 cur_tag = "";
    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      out_ready = ($urandom % 4) != 0;
      in_valid  = ($urandom % 3) != 0;
      in_sign   = 1'($urandom);
      in_dbl    = 1'($urandom);
      in_rnd    = 1'($urandom);
      in_unf_ie = 1'($urandom);
      in_exp    = 12'(int'($urandom % 300) - 20);
      in_frac   = {1'b1, 25'($urandom), 32'($urandom)};
      if (($urandom % 8) == 0) in_frac = {26'h3FF_FFFF, 32'($urandom % 2 == 0 ? 32'hFFFF_FFFF : 32'h8000_0000)};
    end
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule